// File: doc/BRIEF.md
# General-Purpose Pin Bank with Interrupt Detection

This block is one bank of 32 general-purpose pins. Its small memory-mapped register file sets, for each pin, whether the pin is an interrupt source and, if so, which trigger it watches for. The same configuration bits also give the output value when the pin is not an interrupt source. Input pins pass through a two-flop synchronizer before anything looks at them. The synchronized levels can be read back through the register file. They also feed a per-pin trigger detector.

A detected trigger sets the pin's pending flag. A per-pin mask decides whether that flag reaches the single summary interrupt line. Every writable register has three write views: a plain load, a view that sets only the bits written as one, and a view that clears only the bits written as one. Software can therefore change single pins without a read-modify-write. Within a system, banks sit 0x100 bytes apart. Selecting the bank is left to the surrounding address decoder.

Top module: `pin_bank_irq`

## Requirements
- R1: `bus_addr` is the byte offset within the bank, bits 7..2. `bus_addr[5:2]` picks the register: 0 = pin level, 1 = interrupt enable, 2 = mask, 3 = trigger pattern high, 4 = trigger pattern low, 5 = pending flag. `bus_addr[1:0]` picks the write view: 00 = plain load, 01 = set ones, 10 = clear ones, 11 = no write. A read returns the selected register whatever the view. Unused register numbers read zero.
- R2: A write through the set-ones view sets exactly the bits of `bus_wdata` that are one. A write through the clear-ones view clears exactly those bits. Every other bit keeps its value.
- R3: The pin-level register is read-only. It shows `pin_in` after two clock edges of synchronization. Writes to it have no effect.
- R4: When a pin's enable bit is one, its trigger is chosen by {pattern high, pattern low}: 11 = rising edge, 10 = falling edge, 01 = high level, 00 = low level. An edge is the synchronized level differing from its value one cycle earlier.
- R5: A pin whose enable bit is zero never sets its flag. Its `pin_out` bit equals its pattern-low bit. A pin whose enable bit is one drives `pin_out` low.
- R6: A trigger sets the pin's flag on the third rising clock edge after `pin_in` changes. Writing one to the flag's clear-ones view clears the flag on the next edge when no trigger is present.
- R7: `irq_out` is high exactly when some pin has its flag set and its mask bit clear.
- R8: In a level mode the flag is set again every cycle while the active level lasts. A clear only sticks once the pin has left the active level.
- R9: When a trigger and a clear-ones write hit the same flag in the same cycle, the flag stays set.
- R10: Moving a pin between the rising and falling modes at any time takes effect on the next cycle. The old edge is no longer detected.
- R11: After reset, enable, both pattern registers and all flags are zero, the mask is all ones, `irq_out` is low and `pin_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte offset bits 7..2: register number and write view |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for the register `bus_addr` selects (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data for each pin |
| irq_out | output | 1 | Summary interrupt |

## Verification
The bench drives a trigger event and a clear-ones write into the same clock edge. A design that lets the clear win would silently lose that event. It holds a level-high pin active while clearing its flag. A design that treats level modes as one-shot would leave the flag clear. It also switches a pin from rising to falling before any edge arrives, and catches a design that still detects the old edge or misses the new one. It times the pin-level readback to the exact edge, which exposes a missing or extra synchronizer stage. It also writes through the unused view and the read-only register to catch decoding that leaks those writes.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  localparam int OFF_W = 6;

  typedef enum logic [1:0] {
    VIEW_LOAD = 2'b00,
    VIEW_SET  = 2'b01,
    VIEW_CLR  = 2'b10,
    VIEW_NONE = 2'b11
  } view_e;

  localparam logic [3:0] RN_LEVEL = 4'd0;
  localparam logic [3:0] RN_EN    = 4'd1;
  localparam logic [3:0] RN_MASK  = 4'd2;
  localparam logic [3:0] RN_PATH  = 4'd3;
  localparam logic [3:0] RN_PATL  = 4'd4;
  localparam logic [3:0] RN_FLAG  = 4'd5;

  // New value of one register bit for a write through the given view.
  function automatic logic view_bit(logic cur, logic wbit, view_e view);
    case (view)
      VIEW_LOAD: return wbit;
      VIEW_SET:  return cur | wbit;
      VIEW_CLR:  return cur & ~wbit;
      default:   return cur;
    endcase
  endfunction

  // Trigger hit for one pin, given its configuration and synchronized history.
  function automatic logic trig_hit(logic en, logic pat_h, logic pat_l,
                                    logic now_lvl, logic old_lvl);
    logic hit;
    case ({pat_h, pat_l})
      2'b11:   hit = now_lvl & ~old_lvl;
      2'b10:   hit = ~now_lvl & old_lvl;
      2'b01:   hit = now_lvl;
      default: hit = ~now_lvl;
    endcase
    return en & hit;
  endfunction

endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] lvl_now,
  output logic [NPINS-1:0] lvl_old
);
  logic [NPINS-1:0] stage1, stage2, stage3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= pin_in;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign lvl_now = stage2;
  assign lvl_old = stage3;
endmodule

// File: rtl/pbk_regfile.sv
module pbk_regfile
  import pbk_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       reg_num,
  input  view_e            view,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] mask_q,
  output logic [NPINS-1:0] path_q,
  output logic [NPINS-1:0] patl_q
);
  localparam int NCFG = 4;

  logic [NPINS-1:0] cfg_q [NCFG];

  // Configuration registers occupy register numbers 1..NCFG.
  for (genvar r = 0; r < NCFG; r++) begin : g_cfg
    localparam logic [3:0] MY_NUM = 4'(r + 1);
    localparam logic [NPINS-1:0] RST_VAL = (MY_NUM == RN_MASK) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[r] <= RST_VAL;
      end else if (wr_en && reg_num == MY_NUM) begin
        for (int b = 0; b < NPINS; b++)
          cfg_q[r][b] <= view_bit(cfg_q[r][b], wdata[b], view);
      end
    end
  end

  assign en_q   = cfg_q[RN_EN   - 1];
  assign mask_q = cfg_q[RN_MASK - 1];
  assign path_q = cfg_q[RN_PATH - 1];
  assign patl_q = cfg_q[RN_PATL - 1];
endmodule

// File: rtl/pbk_detect.sv
module pbk_detect
  import pbk_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] en_q,
  input  logic [NPINS-1:0] path_q,
  input  logic [NPINS-1:0] patl_q,
  input  logic [NPINS-1:0] lvl_now,
  input  logic [NPINS-1:0] lvl_old,
  output logic [NPINS-1:0] trig_evt
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign trig_evt[p] = trig_hit(en_q[p], path_q[p], patl_q[p],
                                  lvl_now[p], lvl_old[p]);
  end
endmodule

// File: rtl/pbk_flags.sv
module pbk_flags
  import pbk_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       reg_num,
  input  view_e            view,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] trig_evt,
  output logic [NPINS-1:0] flag_q,
  output logic [NPINS-1:0] clr_req
);
  logic             sel;
  logic [NPINS-1:0] flag_d;

  assign sel     = wr_en && (reg_num == RN_FLAG);
  assign clr_req = (sel && view == VIEW_CLR) ? wdata : '0;

  // A trigger is ORed in after the software update, so it wins over a clear.
  always_comb begin
    for (int b = 0; b < NPINS; b++)
      flag_d[b] = (sel ? view_bit(flag_q[b], wdata[b], view) : flag_q[b])
                  | trig_evt[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
  import pbk_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic             irq_out
);
  logic [3:0]       reg_num;
  view_e            view;
  logic [NPINS-1:0] lvl_now, lvl_old;
  logic [NPINS-1:0] en_q, mask_q, path_q, patl_q;
  logic [NPINS-1:0] trig_evt, flag_q, clr_req;
  logic [NPINS-1:0] live_pend;

  assign reg_num = bus_addr[OFF_W-1:2];
  assign view    = view_e'(bus_addr[1:0]);

  pbk_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .lvl_now(lvl_now), .lvl_old(lvl_old)
  );

  pbk_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .reg_num(reg_num),
    .view(view), .wdata(bus_wdata),
    .en_q(en_q), .mask_q(mask_q), .path_q(path_q), .patl_q(patl_q)
  );

  pbk_detect #(.NPINS(NPINS)) u_det (
    .en_q(en_q), .path_q(path_q), .patl_q(patl_q),
    .lvl_now(lvl_now), .lvl_old(lvl_old), .trig_evt(trig_evt)
  );

  pbk_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .reg_num(reg_num),
    .view(view), .wdata(bus_wdata), .trig_evt(trig_evt),
    .flag_q(flag_q), .clr_req(clr_req)
  );

  always_comb begin
    case (reg_num)
      RN_LEVEL: bus_rdata = lvl_now;
      RN_EN:    bus_rdata = en_q;
      RN_MASK:  bus_rdata = mask_q;
      RN_PATH:  bus_rdata = path_q;
      RN_PATL:  bus_rdata = patl_q;
      RN_FLAG:  bus_rdata = flag_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out   = patl_q & ~en_q;
  assign live_pend = flag_q & ~mask_q;
  assign irq_out   = |live_pend;
endmodule

// File: rtl/pbk_checker.sv
module pbk_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] trig_evt,
  input logic [NPINS-1:0] clr_req,
  input logic [NPINS-1:0] flag_q,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] pin_out,
  input logic             irq_out
);
  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt != '0) |=> ((flag_q & $past(trig_evt)) == $past(trig_evt))); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_req & ~trig_evt) != '0) |=> ((flag_q & $past(clr_req & ~trig_evt)) == '0)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_evt & ~en_q) == '0)); // R5
  AST_PINOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & en_q) == '0)); // R5
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out); // R7
  AST_PENDING_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~mask_q) != '0) |-> irq_out); // R7
endmodule

bind pin_bank_irq pbk_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_evt(trig_evt), .clr_req(clr_req),
  .flag_q(flag_q), .mask_q(mask_q), .en_q(en_q), .pin_out(pin_out),
  .irq_out(irq_out)
);

// File: tb/pin_bank_irq_test.sv
module pin_bank_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // Vector fields: {pattern high, pattern low, level before, level after, expected flag}
  localparam logic [4:0] VEC [NV] = '{
    5'b11_01_1, 5'b11_10_0, 5'b11_11_0,
    5'b10_10_1, 5'b10_01_0,
    5'b01_01_1, 5'b01_00_0,
    5'b00_10_1, 5'b00_11_0, 5'b00_00_1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out;
  logic        irq_out;
  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  pin_bank_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] ad(int rn, int vw);
    return {4'(rn), 2'(vw)};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int rn, int vw, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ad(rn, vw); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int rn, output logic [31:0] d);
    bus_addr = ad(rn, 0);
    #1 d = bus_rdata;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // R11 reset values
    rd(1, rv); chk("R11 enable", rv, 32'h0);
    rd(2, rv); chk("R11 mask", rv, 32'hFFFF_FFFF);
    rd(3, rv); chk("R11 pattern high", rv, 32'h0);
    rd(4, rv); chk("R11 pattern low", rv, 32'h0);
    rd(5, rv); chk("R11 flag", rv, 32'h0);
    chk("R11 irq", {31'h0, irq_out}, 32'h0);
    chk("R11 pin_out", pin_out, 32'h0);

    // R2 views; R5 output data from pattern low
    wr(4, 0, 32'hA5A5_0000);
    wr(4, 1, 32'h0000_000F);
    rd(4, rv); chk("R2 set view", rv, 32'hA5A5_000F);
    wr(4, 2, 32'h0005_0003);
    rd(4, rv); chk("R2 clear view", rv, 32'hA5A0_000C);
    chk("R5 pin_out follows pattern low", pin_out, 32'hA5A0_000C);
    wr(1, 1, 32'h0000_0004);
    chk("R5 enabled pin drives low", pin_out, 32'hA5A0_0008);
    // R1 unused view and unused register number
    wr(4, 3, 32'hFFFF_FFFF);
    rd(4, rv); chk("R1 view 11 ignored", rv, 32'hA5A0_000C);
    bus_addr = ad(7, 0); #1 chk("R1 unused number reads zero", bus_rdata, 32'h0);
    wr(1, 0, 32'h0);
    wr(4, 0, 32'h0);

    // R3 level readback latency and read-only
    pins = 32'h8000_0001;
    tick(1); rd(0, rv); chk("R3 one edge still old", rv, 32'h0);
    tick(1); rd(0, rv); chk("R3 after two edges", rv, 32'h8000_0001);
    wr(0, 0, 32'h0000_FFFF);
    rd(0, rv); chk("R3 write ignored", rv, 32'h8000_0001);
    pins = '0; tick(3);

    // R4 trigger modes from table
    for (int i = 0; i < NV; i++) begin
      automatic int p = 2 * i + 1;
      automatic logic [31:0] bm = 32'h1 << p;
      wr(1, 2, bm);
      pins[p] = VEC[i][2];
      tick(4);
      if (VEC[i][4]) wr(3, 1, bm); else wr(3, 2, bm);
      if (VEC[i][3]) wr(4, 1, bm); else wr(4, 2, bm);
      wr(1, 1, bm);
      tick(1);
      wr(5, 2, bm);
      pins[p] = VEC[i][1];
      tick(4);
      rd(5, rv);
      chk($sformatf("R4 vector %0d", i), rv & bm, VEC[i][0] ? bm : 32'h0);
      wr(1, 2, bm);
      pins[p] = 1'b0;
      tick(4);
      wr(5, 2, bm);
    end
    wr(3, 0, 32'h0); wr(4, 0, 32'h0);

    // R6 flag timing and clear
    wr(3, 1, 32'h0001_0000); wr(4, 1, 32'h0001_0000); wr(1, 1, 32'h0001_0000);
    pins[16] = 1'b1;
    tick(2); rd(5, rv); chk("R6 not yet set after two edges", rv, 32'h0);
    tick(1); rd(5, rv); chk("R6 set on third edge", rv, 32'h0001_0000);
    wr(5, 2, 32'h0001_0000);
    rd(5, rv); chk("R6 clear view clears flag", rv, 32'h0);

    // R9 trigger and clear in the same cycle
    pins[16] = 1'b0; tick(4);
    wr(5, 1, 32'h0001_0000);
    pins[16] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(5, 2, 32'h0001_0000);
    rd(5, rv); chk("R9 event beats clear", rv, 32'h0001_0000);
    wr(5, 2, 32'h0001_0000);
    rd(5, rv); chk("R9 later clear works", rv, 32'h0);

    // R10 switch rising to falling before any edge
    pins[16] = 1'b0; tick(4); wr(5, 2, 32'h0001_0000);
    wr(4, 2, 32'h0001_0000);
    pins[16] = 1'b1; tick(4);
    rd(5, rv); chk("R10 old rising edge ignored", rv, 32'h0);
    pins[16] = 1'b0; tick(4);
    rd(5, rv); chk("R10 falling edge caught", rv, 32'h0001_0000);

    // R7 mask and summary line
    chk("R7 masked pending gives no irq", {31'h0, irq_out}, 32'h0);
    wr(2, 2, 32'h0001_0000);
    chk("R7 unmasked pending raises irq", {31'h0, irq_out}, 32'h1);
    wr(5, 2, 32'h0001_0000);
    chk("R7 irq drops after clear", {31'h0, irq_out}, 32'h0);
    wr(1, 2, 32'h0001_0000);

    // R8 level-high re-sets while active
    wr(3, 2, 32'h0000_0200); wr(4, 1, 32'h0000_0200);
    pins[9] = 1'b1; tick(4);
    wr(1, 1, 32'h0000_0200); tick(2);
    wr(5, 2, 32'h0000_0200);
    rd(5, rv); chk("R8 flag back while level active", rv & 32'h200, 32'h200);
    pins[9] = 1'b0; tick(4);
    wr(5, 2, 32'h0000_0200);
    rd(5, rv); chk("R8 clear sticks after level ends", rv & 32'h200, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule